// File: doc/BRIEF.md
# DMA Controller Host Register Interface

This block is the byte-wide host register file of a four-channel DMA controller. A host reaches it through single-cycle read and write strobes at small port offsets. Each channel has a 16-bit base and current address and a 16-bit base and current count. All of them pass through one 8-bit port per register. A shared byte-pointer flip-flop chooses the low or high byte, and every access to a channel port toggles it. The block also holds a mode byte for each channel, the per-channel mask bits, a command byte, the software request bits and a status byte. It drives this configuration to the channel engines as plain outputs.

The channel engines pulse a per-channel step input once for each transfer. On a step, the current address goes up by one and the current count goes down by one. A step taken at count zero is the terminal count. It latches a status bit. It reloads both current registers from the base registers when the channel's autoinit bit is set. Otherwise the count wraps to 0xFFFF. A parameter doubles every port offset for the word-wide controller instance, and in that case odd offsets are not decoded.

Host accesses are plain strobes with no back-pressure. A write takes effect at the clock edge on which `wr_en_i` is high. `rdata_o` is combinational and valid during the cycle in which `rd_en_i` is high. Any side effect of a read (a pointer toggle or a status clear) takes effect at the end of that cycle.

Top module: `dma_host_regs`

## Requirements
- R1: After reset all four mask bits are 1, the byte pointer selects the low byte, and the command byte, software requests, latched terminal counts and all address and count registers are 0.
- R2: With the default byte-wide layout, channel n's address port is at offset 2n and its count port at 2n+1. Two consecutive writes to a port load its low byte and then its high byte into both the base and the current register. With the word-wide parameter set, every offset is doubled.
- R3: Every read or write of an address or count port toggles the byte pointer. A read returns the selected byte of the current address or current count.
- R4: A write of any value to offset 0x0C makes the next channel-port access use the low byte.
- R5: A write to offset 0x0A changes one mask bit. Data bits 1:0 name the channel, and data bit 2 gives the new mask value (1 masks the channel, 0 unmasks it).
- R6: A write to offset 0x0E clears all four mask bits. A write to offset 0x0F loads the mask bits from data bits 3:0, with bit n for channel n.
- R7: A write to offset 0x0B stores data bits 7:2 as the mode of the channel named by data bits 1:0. `mode_o` carries them as bits 5:0. Mode bit 2 (data bit 4) is autoinit.
- R8: A write to offset 0x08 loads `cmd_o`. A write to offset 0x09 sets (data bit 2 = 1) or clears (data bit 2 = 0) the software request of the channel named by data bits 1:0.
- R9: A step pulse increments the channel's current address and decrements its current count. A step at count 0 raises `tc_o` for that channel in the same cycle. The count then wraps to 0xFFFF, unless autoinit is set, in which case both current registers reload from the base registers.
- R10: A read of offset 0x08 returns the status byte. Bit n (n = 0..3) is channel n's latched terminal count. Bit 4+n is channel n's software request OR its `dreq_i` bit. The read clears the latched bits, except that a terminal count arriving in the same cycle stays set.
- R11: A write to offset 0x08+5 (0x0D), the master clear, resets the byte pointer, sets all mask bits, and clears the command byte, software requests and latched terminal counts.
- R12: An access to an offset outside the decoded range (address bit 4 set in the byte-wide layout) changes no state, does not toggle the pointer, and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | ADDR_W | Host port offset |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, valid while rd_en_i is high |
| dreq_i | input | 4 | Hardware request lines, shown in status bits 7:4 |
| step_i | input | 4 | One transfer completed, per channel |
| tc_o | output | 4 | Terminal count reached on this step, per channel |
| mask_o | output | 4 | Channel mask bits |
| cmd_o | output | 8 | Command byte |
| sw_req_o | output | 4 | Software request bits |
| mode_o | output | 4x6 | Mode bits per channel |
| base_addr_o | output | 4x16 | Base address per channel |
| base_cnt_o | output | 4x16 | Base count per channel |
| cur_addr_o | output | 4x16 | Current address per channel |
| cur_cnt_o | output | 4x16 | Current count per channel |

## Verification
The bench aims at the byte pointer. A write of one lone byte, followed by a pointer clear, must leave the next pair landing low then high. A design that forgot to clear the pointer, or that toggled it only on writes, would swap the bytes or return the high count byte first. The count wrap is tested at zero: a missing wrap or a missing terminal count would leave the count at 0 and the status bit clear. An autoinit reload that reloaded only one of the two current registers would show the wrong address after the third step. Status reads are issued twice to catch a latch that never clears. Accesses with address bit 4 set catch a decoder that ignores that bit and aliases onto the real registers.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int NCH = 4;
  localparam int AW  = 16;

  // decoded register index (byte-wide offset); order fixed by the port map
  localparam logic [3:0] IX_CMD_STAT = 4'h8;
  localparam logic [3:0] IX_REQ      = 4'h9;
  localparam logic [3:0] IX_MASK1    = 4'hA;
  localparam logic [3:0] IX_MODE     = 4'hB;
  localparam logic [3:0] IX_CLRPTR   = 4'hC;
  localparam logic [3:0] IX_MCLR     = 4'hD;
  localparam logic [3:0] IX_CLRMASK  = 4'hE;
  localparam logic [3:0] IX_MASKALL  = 4'hF;

  typedef struct packed {
    logic       hit;
    logic [3:0] idx;
  } port_sel_t;
endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_regs_pkg::*;
#(
  parameter bit WORD_CTRL = 1'b0,
  parameter int ADDR_W    = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output port_sel_t         sel_o
);
  localparam int SH   = WORD_CTRL ? 1 : 0;
  localparam int SPAN = 4 + SH;

  logic lsb_ok, top_ok;

  generate
    if (WORD_CTRL) begin : g_word
      assign lsb_ok = ~addr_i[0];
    end else begin : g_byte
      assign lsb_ok = 1'b1;
    end
    if (ADDR_W > SPAN) begin : g_top
      assign top_ok = (addr_i[ADDR_W-1:SPAN] == '0);
    end else begin : g_notop
      assign top_ok = 1'b1;
    end
  endgenerate

  assign sel_o.hit = lsb_ok & top_ok;
  assign sel_o.idx = addr_i[SH +: 4];
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_addr_i,
  input  logic          wr_cnt_i,
  input  logic          hi_byte_i,
  input  logic [7:0]    wdata_i,
  input  logic          step_i,
  input  logic          autoinit_i,
  output logic [AW-1:0] base_addr_o,
  output logic [AW-1:0] base_cnt_o,
  output logic [AW-1:0] cur_addr_o,
  output logic [AW-1:0] cur_cnt_o,
  output logic          tc_o
);
  logic host_wr;
  assign host_wr = wr_addr_i | wr_cnt_i;
  assign tc_o    = step_i & (cur_cnt_o == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_o <= '0;
      base_cnt_o  <= '0;
      cur_addr_o  <= '0;
      cur_cnt_o   <= '0;
    end else if (host_wr) begin
      if (wr_addr_i) begin
        if (hi_byte_i) begin
          base_addr_o[15:8] <= wdata_i;
          cur_addr_o[15:8]  <= wdata_i;
        end else begin
          base_addr_o[7:0] <= wdata_i;
          cur_addr_o[7:0]  <= wdata_i;
        end
      end
      if (wr_cnt_i) begin
        if (hi_byte_i) begin
          base_cnt_o[15:8] <= wdata_i;
          cur_cnt_o[15:8]  <= wdata_i;
        end else begin
          base_cnt_o[7:0] <= wdata_i;
          cur_cnt_o[7:0]  <= wdata_i;
        end
      end
    end else if (step_i) begin
      if (tc_o && autoinit_i) begin
        cur_addr_o <= base_addr_o;
        cur_cnt_o  <= base_cnt_o;
      end else begin
        cur_addr_o <= cur_addr_o + 1'b1;
        cur_cnt_o  <= cur_cnt_o - 1'b1;
      end
    end
  end

  AST_AUTOINIT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_o && autoinit_i && !host_wr) |=> (cur_cnt_o == $past(base_cnt_o) && cur_addr_o == $past(base_addr_o))); // R9
  AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_o && !autoinit_i && !host_wr) |=> (cur_cnt_o == 16'hFFFF)); // R9
endmodule

// File: rtl/dma_host_regs.sv
module dma_host_regs
  import dma_regs_pkg::*;
#(
  parameter bit WORD_CTRL = 1'b0,
  parameter int ADDR_W    = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic                     rd_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [7:0]               wdata_i,
  output logic [7:0]               rdata_o,
  input  logic [NCH-1:0]           dreq_i,
  input  logic [NCH-1:0]           step_i,
  output logic [NCH-1:0]           tc_o,
  output logic [NCH-1:0]           mask_o,
  output logic [7:0]               cmd_o,
  output logic [NCH-1:0]           sw_req_o,
  output logic [NCH-1:0][5:0]      mode_o,
  output logic [NCH-1:0][AW-1:0]   base_addr_o,
  output logic [NCH-1:0][AW-1:0]   base_cnt_o,
  output logic [NCH-1:0][AW-1:0]   cur_addr_o,
  output logic [NCH-1:0][AW-1:0]   cur_cnt_o
);
  port_sel_t sel;
  logic      ptr_hi;
  logic [NCH-1:0] stat_tc;

  dma_port_decode #(.WORD_CTRL(WORD_CTRL), .ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  logic       wr, rd, chan_port, stat_rd, mclr;
  logic [1:0] acc_ch, data_ch;
  assign wr        = wr_en_i & sel.hit;
  assign rd        = rd_en_i & sel.hit;
  assign chan_port = ~sel.idx[3];
  assign acc_ch    = sel.idx[2:1];
  assign data_ch   = wdata_i[1:0];
  assign stat_rd   = rd & (sel.idx == IX_CMD_STAT);
  assign mclr      = wr & (sel.idx == IX_MCLR);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic sel_ch;
      assign sel_ch = wr & chan_port & (acc_ch == c[1:0]);
      dma_chan_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_addr_i   (sel_ch & ~sel.idx[0]),
        .wr_cnt_i    (sel_ch &  sel.idx[0]),
        .hi_byte_i   (ptr_hi),
        .wdata_i     (wdata_i),
        .step_i      (step_i[c]),
        .autoinit_i  (mode_o[c][2]),
        .base_addr_o (base_addr_o[c]),
        .base_cnt_o  (base_cnt_o[c]),
        .cur_addr_o  (cur_addr_o[c]),
        .cur_cnt_o   (cur_cnt_o[c]),
        .tc_o        (tc_o[c])
      );
    end
  endgenerate

  // byte pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                              ptr_hi <= 1'b0;
    else if (wr && (sel.idx == IX_CLRPTR || sel.idx == IX_MCLR)) ptr_hi <= 1'b0;
    else if ((wr || rd) && chan_port)                        ptr_hi <= ~ptr_hi;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o   <= '1;
      cmd_o    <= '0;
      sw_req_o <= '0;
      mode_o   <= '0;
    end else if (mclr) begin
      mask_o   <= '1;
      cmd_o    <= '0;
      sw_req_o <= '0;
    end else if (wr) begin
      case (sel.idx)
        IX_CMD_STAT: cmd_o             <= wdata_i;
        IX_REQ:      sw_req_o[data_ch] <= wdata_i[2];
        IX_MASK1:    mask_o[data_ch]   <= wdata_i[2];
        IX_MODE:     mode_o[data_ch]   <= wdata_i[7:2];
        IX_CLRMASK:  mask_o            <= '0;
        IX_MASKALL:  mask_o            <= wdata_i[NCH-1:0];
        default: ;
      endcase
    end
  end

  // latched terminal counts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_tc <= '0;
    else if (mclr)    stat_tc <= '0;
    else if (stat_rd) stat_tc <= tc_o;
    else              stat_tc <= stat_tc | tc_o;
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (chan_port) begin
        if (sel.idx[0]) rdata_o = ptr_hi ? cur_cnt_o[acc_ch][15:8]  : cur_cnt_o[acc_ch][7:0];
        else            rdata_o = ptr_hi ? cur_addr_o[acc_ch][15:8] : cur_addr_o[acc_ch][7:0];
      end else if (sel.idx == IX_CMD_STAT) begin
        rdata_o = {sw_req_o | dreq_i, stat_tc};
      end
    end
  end

  AST_RESET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (mask_o == '1 && cmd_o == '0 && sw_req_o == '0)); // R11
  AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr || rd) && chan_port) |=> (ptr_hi != $past(ptr_hi))); // R3
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel.idx == IX_CLRPTR) |=> !ptr_hi); // R4
  AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && tc_o == '0 && !mclr) |=> (stat_tc == '0)); // R10
  AST_TC_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_o != '0 && !mclr) |=> ((stat_tc & $past(tc_o)) == $past(tc_o))); // R10
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel.hit && !mclr) |=> ($stable(ptr_hi) && $stable(mask_o) && $stable(cmd_o))); // R12
endmodule

// File: tb/tb_dma_host_regs.sv
module tb_dma_host_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] dreq = '0, step = '0, tc, mask, sw_req;
  logic [7:0] cmd;
  logic [3:0][5:0]  mode;
  logic [3:0][15:0] base_addr, base_cnt, cur_addr, cur_cnt;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  dma_host_regs dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .dreq_i(dreq), .step_i(step), .tc_o(tc),
    .mask_o(mask), .cmd_o(cmd), .sw_req_o(sw_req), .mode_o(mode),
    .base_addr_o(base_addr), .base_cnt_o(base_cnt), .cur_addr_o(cur_addr),
    .cur_cnt_o(cur_cnt)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(logic [3:0] m, output logic [3:0] t);
    @(negedge clk); step = m;
    #1 t = tc;
    @(negedge clk); step = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 mask", mask, 4'hF);
    check("R1 cmd", cmd, 0);
    check("R1 sw_req", sw_req, 0);
    check("R1 cur_cnt", cur_cnt[3], 0);
    rd(5'h08, d); check("R1 status", d, 8'h00);
  endtask

  task automatic t_addr_count();
    logic [7:0] d;
    wr(5'h0C, 8'h00);
    wr(5'h02, 8'h34); wr(5'h02, 8'h12);
    check("R2 base addr ch1", base_addr[1], 16'h1234);
    check("R2 cur addr ch1", cur_addr[1], 16'h1234);
    wr(5'h03, 8'h01); wr(5'h03, 8'h00);
    check("R2 base cnt ch1", base_cnt[1], 16'h0001);
    rd(5'h03, d); check("R3 cnt low", d, 8'h01);
    rd(5'h03, d); check("R3 cnt high", d, 8'h00);
    rd(5'h02, d); check("R3 addr low", d, 8'h34);
    rd(5'h02, d); check("R3 addr high", d, 8'h12);
  endtask

  task automatic t_clrptr();
    wr(5'h00, 8'hAA);
    wr(5'h0C, 8'h5A);
    wr(5'h00, 8'h55); wr(5'h00, 8'h66);
    check("R4 byte order after clear", base_addr[0], 16'h6655);
  endtask

  task automatic t_mask();
    wr(5'h0A, 8'h01); check("R5 unmask ch1", mask, 4'hD);
    wr(5'h0A, 8'h05); check("R5 mask ch1", mask, 4'hF);
    wr(5'h0E, 8'h00); check("R6 clear all", mask, 4'h0);
    wr(5'h0F, 8'h0A); check("R6 write all", mask, 4'hA);
  endtask

  task automatic t_mode();
    wr(5'h0B, 8'h4B);
    check("R7 mode ch3", mode[3], 6'h12);
    check("R7 mode ch0 untouched", mode[0], 6'h00);
  endtask

  task automatic t_cmd_req();
    logic [7:0] d;
    wr(5'h08, 8'hA5); check("R8 cmd", cmd, 8'hA5);
    wr(5'h09, 8'h04); check("R8 sw req set", sw_req, 4'h1);
    wr(5'h09, 8'h06); wr(5'h09, 8'h02);
    check("R8 sw req clear", sw_req, 4'h1);
    dreq = 4'h8;
    rd(5'h08, d); check("R10 status requests", d, 8'h90);
  endtask

  task automatic t_step();
    logic [3:0] t;
    logic [7:0] d;
    pulse(4'h2, t); check("R9 no tc", t, 4'h0);
    check("R9 addr inc", cur_addr[1], 16'h1235);
    check("R9 cnt dec", cur_cnt[1], 16'h0000);
    pulse(4'h2, t); check("R9 tc pulse", t, 4'h2);
    check("R9 count wrap", cur_cnt[1], 16'hFFFF);
    rd(5'h08, d); check("R10 tc latched", d, 8'h92);
    rd(5'h08, d); check("R10 tc cleared by read", d, 8'h90);
  endtask

  task automatic t_autoinit();
    logic [3:0] t;
    wr(5'h0B, 8'h56);
    check("R7 autoinit bit", mode[2][2], 1);
    wr(5'h0C, 8'h00);
    wr(5'h04, 8'h10); wr(5'h04, 8'h00);
    wr(5'h05, 8'h02); wr(5'h05, 8'h00);
    pulse(4'h4, t); pulse(4'h4, t);
    check("R9 pre-tc addr", cur_addr[2], 16'h0012);
    pulse(4'h4, t); check("R9 autoinit tc", t, 4'h4);
    check("R9 reload cnt", cur_cnt[2], 16'h0002);
    check("R9 reload addr", cur_addr[2], 16'h0010);
  endtask

  task automatic t_mclr();
    logic [7:0] d;
    wr(5'h00, 8'h77);
    wr(5'h0D, 8'h00);
    check("R11 mask set", mask, 4'hF);
    check("R11 cmd clear", cmd, 0);
    check("R11 req clear", sw_req, 0);
    rd(5'h08, d); check("R11 status clear", d, 8'h80);
    wr(5'h00, 8'h22); wr(5'h00, 8'h33);
    check("R11 pointer reset", base_addr[0], 16'h3322);
  endtask

  task automatic t_unused();
    logic [7:0] d;
    wr(5'h1E, 8'h00); check("R12 mask untouched", mask, 4'hF);
    wr(5'h12, 8'h99); wr(5'h12, 8'h88);
    check("R12 addr untouched", base_addr[1], 16'h1234);
    rd(5'h10, d); check("R12 read zero", d, 8'h00);
    wr(5'h00, 8'h44); wr(5'h00, 8'h11);
    check("R12 pointer untouched", base_addr[0], 16'h1144);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_count();
    t_clrptr();
    t_mask();
    t_mode();
    t_cmd_req();
    t_step();
    t_autoinit();
    t_mclr();
    t_unused();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule